// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block merges twelve event sources into a single active-low interrupt request that can share a wired line with other devices. Eight of the sources are countdown timers. Each timer supplies a level that is high while its count is zero. The other four sources are condition levels from external detectors: far-end signal too strong, far-end signal too weak, poor signal-to-noise ratio, and scrambler synchronisation found. Each source has a sticky status bit and an enable bit. The request is driven low while any status bit is set and its enable bit is also set.

A host reaches the block through a small synchronous register port. The port has a write strobe, an address and write data, and read data is decoded from the address without a clock. Two enable registers select which sources may raise the request. Two status registers show which sources have fired, and the host clears a status bit by writing 1 to it. The two kinds of source latch by different rules. A timer bit latches only on the cycle its level goes from low to high. An alarm bit is held set for as long as its condition is present, so the host cannot clear it until the condition has gone away.

Top module: `irq_merge`

## Requirements
- R1: After reset, both enable registers and both status registers read 0, and `irq_oe` is 0.
- R2: The timer enable register is at address 0x02, with bit i enabling timer i. The alarm enable register is at address 0x03, where bit 0 is far-end high, bit 1 is far-end low, bit 2 is SNR and bit 3 is sync detect. Bits 7:4 of 0x03 read 0. Both registers are written by a host write and read back the written value.
- R3: Timer status is at 0x04 and alarm status is at 0x05, using the same bit positions as R2. In a write to a status address, each 1 bit clears that status bit on the next clock, and each 0 bit leaves its status bit unchanged.
- R4: A timer status bit is set on the clock after its `tmr_zero` input goes from 0 to 1. If the input stays at 1, the bit is not set again after it has been cleared.
- R5: An alarm status bit is set on every clock where its `alm_lvl` input is 1. A write that tries to clear the bit while the level is 1 has no effect. Once the level has fallen to 0, the bit stays set until it is cleared.
- R6: `irq_oe` is 1 exactly when some status bit and its enable bit are both 1. `irq_dat` is always 0.
- R7: A source whose enable bit is 0 still latches its status bit but does not raise `irq_oe`.
- R8: If a timer's 0-to-1 edge and a clear of the same bit fall on the same clock, the bit ends up set.
- R9: A timer input that is already 1 when reset is released does not latch its status bit.
- R10: Addresses other than 0x02 to 0x05 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_zero | input | N_TMR | Per-timer level, 1 while that timer's count is zero |
| alm_lvl | input | N_ALM | Per-alarm condition level |
| host_we | input | 1 | Host write strobe, sampled on the clock edge |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data decoded from `host_addr` |
| irq_oe | output | 1 | Open-drain enable, 1 pulls the request line low |
| irq_dat | output | 1 | Open-drain data value, constant 0 |

## Verification
The bench builds the block with its default sizes: eight timers, four alarms and 8-bit registers. At these sizes every status and enable bit sits at its real register position, and the full address space of 256 locations can be reached by random addresses. This makes it possible to exercise stray-address writes, partial write-1-to-clear masks, and clears that land on the same clock as a timer edge or while an alarm is held active. A second reset with every timer held at zero shows that release from reset does not count as an edge.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TMR_EN,
    SEL_ALM_EN,
    SEL_TMR_ST,
    SEL_ALM_ST
  } reg_sel_e;

  // Rising edge of a level, given its value one clock earlier.
  function automatic logic edge_up(input logic now_lvl, input logic was_lvl);
    return now_lvl & ~was_lvl;
  endfunction

  // Next sticky status value: a set wins over a clear in the same clock.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_merge_regs.sv
module irq_merge_regs
  import irq_merge_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned N_TMR     = 8,
  parameter int unsigned N_ALM     = 4,
  parameter int unsigned TMR_EN_AD = 2,
  parameter int unsigned ALM_EN_AD = 3,
  parameter int unsigned TMR_ST_AD = 4,
  parameter int unsigned ALM_ST_AD = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [N_TMR-1:0] tmr_stat,
  input  logic [N_ALM-1:0] alm_stat,
  output logic [N_TMR-1:0] tmr_mask,
  output logic [N_ALM-1:0] alm_mask,
  output logic [N_TMR-1:0] tmr_clr,
  output logic [N_ALM-1:0] alm_clr,
  output logic [DW-1:0]    rdata
);

  reg_sel_e sel;

  always_comb begin
    if (addr == AW'(TMR_EN_AD))      sel = SEL_TMR_EN;
    else if (addr == AW'(ALM_EN_AD)) sel = SEL_ALM_EN;
    else if (addr == AW'(TMR_ST_AD)) sel = SEL_TMR_ST;
    else if (addr == AW'(ALM_ST_AD)) sel = SEL_ALM_ST;
    else                             sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_mask <= '0;
      alm_mask <= '0;
    end else if (we) begin
      if (sel == SEL_TMR_EN) tmr_mask <= wdata[N_TMR-1:0];
      if (sel == SEL_ALM_EN) alm_mask <= wdata[N_ALM-1:0];
    end
  end

  assign tmr_clr = (we && sel == SEL_TMR_ST) ? wdata[N_TMR-1:0] : '0;
  assign alm_clr = (we && sel == SEL_ALM_ST) ? wdata[N_ALM-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_TMR_EN: rdata[N_TMR-1:0] = tmr_mask;
      SEL_ALM_EN: rdata[N_ALM-1:0] = alm_mask;
      SEL_TMR_ST: rdata[N_TMR-1:0] = tmr_stat;
      SEL_ALM_ST: rdata[N_ALM-1:0] = alm_stat;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_merge_tmr_bank.sv
module irq_merge_tmr_bank
  import irq_merge_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] zero_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] rise,
  output logic [N-1:0] stat
);

  for (genvar i = 0; i < N; i++) begin : g_tmr
    logic was_zero;

    assign rise[i] = edge_up(zero_in[i], was_zero);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        was_zero <= 1'b1;
        stat[i]  <= 1'b0;
      end else begin
        was_zero <= zero_in[i];
        stat[i]  <= sticky_next(stat[i], rise[i], clr[i]);
      end
    end
  end

endmodule

// File: rtl/irq_merge_alm_bank.sv
module irq_merge_alm_bank
  import irq_merge_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);

  for (genvar i = 0; i < N; i++) begin : g_alm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= sticky_next(stat[i], lvl[i], clr[i]);
    end
  end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned N_TMR     = 8,
  parameter int unsigned N_ALM     = 4,
  parameter int unsigned TMR_EN_AD = 2,
  parameter int unsigned ALM_EN_AD = 3,
  parameter int unsigned TMR_ST_AD = 4,
  parameter int unsigned ALM_ST_AD = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] tmr_zero,
  input  logic [N_ALM-1:0] alm_lvl,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             irq_oe,
  output logic             irq_dat
);

  logic [N_TMR-1:0] tmr_mask, tmr_clr, tmr_rise, tmr_stat;
  logic [N_ALM-1:0] alm_mask, alm_clr, alm_stat;

  irq_merge_regs #(
    .AW(AW), .DW(DW), .N_TMR(N_TMR), .N_ALM(N_ALM),
    .TMR_EN_AD(TMR_EN_AD), .ALM_EN_AD(ALM_EN_AD),
    .TMR_ST_AD(TMR_ST_AD), .ALM_ST_AD(ALM_ST_AD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .tmr_stat(tmr_stat), .alm_stat(alm_stat),
    .tmr_mask(tmr_mask), .alm_mask(alm_mask),
    .tmr_clr(tmr_clr), .alm_clr(alm_clr), .rdata(host_rdata)
  );

  irq_merge_tmr_bank #(.N(N_TMR)) u_tmr (
    .clk(clk), .rst_n(rst_n), .zero_in(tmr_zero), .clr(tmr_clr),
    .rise(tmr_rise), .stat(tmr_stat)
  );

  irq_merge_alm_bank #(.N(N_ALM)) u_alm (
    .clk(clk), .rst_n(rst_n), .lvl(alm_lvl), .clr(alm_clr), .stat(alm_stat)
  );

  assign irq_oe  = (|(tmr_stat & tmr_mask)) | (|(alm_stat & alm_mask));
  assign irq_dat = 1'b0;

endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int unsigned N_TMR = 8,
  parameter int unsigned N_ALM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_TMR-1:0] tmr_rise,
  input logic [N_TMR-1:0] tmr_stat,
  input logic [N_TMR-1:0] tmr_clr,
  input logic [N_TMR-1:0] tmr_mask,
  input logic [N_ALM-1:0] alm_lvl,
  input logic [N_ALM-1:0] alm_stat,
  input logic [N_ALM-1:0] alm_mask,
  input logic             irq_oe
);

  // R4
  timer_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rise != '0) |=> ((tmr_stat & $past(tmr_rise)) == $past(tmr_rise)));

  // R4
  timer_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_stat & ~$past(tmr_stat) & ~$past(tmr_rise)) == '0));

  // R5
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_lvl != '0) |=> ((alm_stat & $past(alm_lvl)) == $past(alm_lvl)));

  // R3
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr != '0) |=> ((tmr_stat & $past(tmr_clr & ~tmr_rise)) == '0));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_mask == '0 && alm_mask == '0) |-> !irq_oe);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> ((tmr_stat != '0) || (alm_stat != '0)));

endmodule

bind irq_merge irq_merge_chk #(.N_TMR(N_TMR), .N_ALM(N_ALM)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tmr_rise(tmr_rise), .tmr_stat(tmr_stat), .tmr_clr(tmr_clr), .tmr_mask(tmr_mask),
  .alm_lvl(alm_lvl), .alm_stat(alm_stat), .alm_mask(alm_mask), .irq_oe(irq_oe)
);

// File: tb/test_irq_merge.sv
`timescale 1ns/1ps
module test_irq_merge;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tz = '0;
  logic [3:0] al = '0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       oe, dat;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_merge i_irq_merge (
    .clk(clk), .rst_n(rst_n), .tmr_zero(tz), .alm_lvl(al),
    .host_we(we), .host_addr(addr), .host_wdata(wd),
    .host_rdata(rd), .irq_oe(oe), .irq_dat(dat)
  );

  // behavioural reference model
  bit m_ts[8];
  bit m_prev[8];
  bit m_as[4];
  int m_tm, m_am;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_ts[i] = 0; m_prev[i] = 1; end
      for (int i = 0; i < 4; i++) m_as[i] = 0;
      m_tm = 0; m_am = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (we && addr == 4 && wd[i]) m_ts[i] = 0;
        if (tz[i] && !m_prev[i]) m_ts[i] = 1;
        m_prev[i] = tz[i];
      end
      for (int i = 0; i < 4; i++) begin
        if (we && addr == 5 && wd[i]) m_as[i] = 0;
        if (al[i]) m_as[i] = 1;
      end
      if (we && addr == 2) m_tm = wd;
      if (we && addr == 3) m_am = wd % 16;
    end
  end

  function automatic int m_read(int a);
    int v = 0;
    case (a)
      2: v = m_tm;
      3: v = m_am;
      4: for (int i = 0; i < 8; i++) if (m_ts[i]) v += (1 << i);
      5: for (int i = 0; i < 4; i++) if (m_as[i]) v += (1 << i);
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic int m_irq();
    for (int i = 0; i < 8; i++) if (m_ts[i] && ((m_tm >> i) & 1)) return 1;
    for (int i = 0; i < 4; i++) if (m_as[i] && ((m_am >> i) & 1)) return 1;
    return 0;
  endfunction

  task automatic chk(input int act, input int exp, input string req, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] ntz, input logic [3:0] nal, input logic nwe,
                      input logic [7:0] na, input logic [7:0] nwd);
    @(negedge clk);
    chk(int'(rd), m_read(int'(addr)), "R2 R3 R10", "rdata");
    chk(int'(oe), m_irq(), "R6 R7", "irq_oe");
    chk(int'(dat), 0, "R6", "irq_dat");
    tz = ntz; al = nal; we = nwe; addr = na; wd = nwd;
  endtask

  task automatic peek(input logic [7:0] a, input int exp, input string req);
    step(tz, al, 1'b0, a, 8'h00);
    #1 chk(int'(rd), exp, req, "readback");
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(tz, al, 1'b1, a, d);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    peek(8'h02, 0, "R1"); peek(8'h03, 0, "R1");
    peek(8'h04, 0, "R1"); peek(8'h05, 0, "R1");
    chk(int'(oe), 0, "R1", "irq_oe");
    // R2
    wr(8'h02, 8'hA5); peek(8'h02, 'hA5, "R2");
    wr(8'h03, 8'hFF); peek(8'h03, 'h0F, "R2");
    wr(8'h02, 8'h00); wr(8'h03, 8'h00);
    // R7 then R6
    step(8'h01, 4'h0, 1'b0, 8'h00, 8'h00);
    peek(8'h04, 'h01, "R7");
    chk(int'(oe), 0, "R7", "irq_oe masked");
    wr(8'h02, 8'h01);
    peek(8'h04, 'h01, "R6");
    chk(int'(oe), 1, "R6", "irq_oe enabled");
    // R4: clear while held at zero, no relatch
    wr(8'h04, 8'h01);
    peek(8'h04, 0, "R4");
    peek(8'h04, 0, "R4");
    chk(int'(oe), 0, "R6", "irq_oe after clear");
    // R8
    step(8'h00, 4'h0, 1'b0, 8'h00, 8'h00);
    step(8'h01, 4'h0, 1'b1, 8'h04, 8'h01);
    peek(8'h04, 'h01, "R8");
    wr(8'h04, 8'h01); peek(8'h04, 0, "R3");
    // R3 partial clear
    step(8'h07, 4'h0, 1'b0, 8'h00, 8'h00);
    peek(8'h04, 'h06, "R4");
    wr(8'h04, 8'h02); peek(8'h04, 'h04, "R3");
    wr(8'h04, 8'hFF); peek(8'h04, 0, "R3");
    // R5
    step(tz, 4'h4, 1'b0, 8'h00, 8'h00);
    peek(8'h05, 'h4, "R5");
    wr(8'h05, 8'h04); peek(8'h05, 'h4, "R5");
    step(tz, 4'h0, 1'b0, 8'h00, 8'h00);
    peek(8'h05, 'h4, "R5");
    wr(8'h05, 8'h04); peek(8'h05, 0, "R3");
    wr(8'h03, 8'h01);
    step(tz, 4'h1, 1'b0, 8'h00, 8'h00);
    peek(8'h05, 'h1, "R5");
    chk(int'(oe), 1, "R6", "irq_oe alarm");
    step(tz, 4'h0, 1'b0, 8'h00, 8'h00);
    wr(8'h05, 8'h01); wr(8'h03, 8'h00);
    // R10
    wr(8'h06, 8'hFF); peek(8'h06, 0, "R10");
    peek(8'h02, 'h01, "R10");
    wr(8'h82, 8'hFF); peek(8'h82, 0, "R10");
    peek(8'h02, 'h01, "R10");
    // random traffic, compared every clock
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ra;
      ra = ($urandom % 4 != 0) ? 8'(2 + $urandom % 4) : 8'($urandom);
      step(($urandom % 3 == 0) ? 8'($urandom) : tz, 4'($urandom),
           1'($urandom % 3 == 0), ra, 8'($urandom));
    end
    // R9
    step(8'hFF, 4'h0, 1'b0, 8'h04, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(8'hFF, 4'h0, 1'b0, 8'h04, 8'h00);
    step(8'hFF, 4'h0, 1'b0, 8'h04, 8'h00);
    peek(8'h04, 0, "R9");
    step(8'h00, 4'h0, 1'b0, 8'h04, 8'h00);
    step(8'hFF, 4'h0, 1'b0, 8'h04, 8'h00);
    peek(8'h04, 'hFF, "R4");
    step(tz, al, 1'b0, 8'h00, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule